// File: doc/BRIEF.md
# SMBus Transaction Register Sequencer

This block runs one complete SMBus transaction each time the host writes its protocol register. The host first fills a small register file with the target address, the command byte, up to 32 data bytes and a byte count. Writing the protocol register then starts the transaction. The sequencer turns the protocol code into an ordered series of byte-level bus operations and hands them one at a time to a separate byte-level bus engine through a request/acknowledge handshake. The operations are start (which also serves as repeated start), stop, write byte and read byte. Bytes read from the bus are stored back into the same register file. When the transaction ends, a done flag and a five-bit result code appear in the status register.

Packet error checking is optional. When it is enabled, the block keeps a running CRC-8 over every byte that crosses the bus, address bytes included. It appends the CRC on writes and compares it on reads. Target NACKs, a bus engine that stops responding, and unknown protocol codes each end the transaction with their own result code.

Top module: `smbus_seq`

## Requirements
- R1: After reset, the status register (offset 0x01) reads 0x00 and opReq is low.
- R2: A host write to the protocol register (offset 0x00) while idle clears status bit 7 (done) by the next cycle and starts a transaction. A protocol write while a transaction runs is ignored: the register keeps its value and no second transaction follows.
- R3: opReq stays high with opKind and opByte unchanged until opAck is seen. opKind encodes 0 = start, 1 = stop, 2 = write byte, 3 = read byte.
- R4: Protocol code 0x02/0x03 (quick) issues start, the address byte and stop. The address byte is the address register (offset 0x02, target address in bits 7:1) with bit 0 replaced by protocol bit 0.
- R5: Codes 0x04/0x05 (byte), 0x06/0x07 (byte data) and 0x08/0x09 (word) follow the SMBus sequences. Bit 0 = 1 selects read. Reads of byte data and word send the command byte (offset 0x03), then a repeated start and the read address. Word data has its low byte at offset 0x04 and its high byte at offset 0x05.
- R6: Codes 0x0A/0x0B (block) send or receive a count byte ahead of the data. The count register (offset 0x24) never holds more than 32. A received count is clamped to 32, stored there, and followed by that many data reads.
- R7: Code 0x0C (process call) writes the command and two data bytes, then a repeated start reads two bytes back into offsets 0x04/0x05. Code 0x0D does the same with a count byte and block data.
- R8: Codes 0x4A/0x4B (raw I2C block) send no count byte. The length comes from the count register.
- R9: Every read byte is acknowledged (opNackLast = 0) except the final byte of the transaction, which has opNackLast = 1.
- R10: A target NACK on an address byte stops the transaction and gives status 0x90. A NACK on any other written byte gives status 0x91.
- R11: Protocol bit 7 enables packet error checking for all codes except quick and raw I2C block. The CRC-8 uses polynomial 0x07, an initial value of 0 and MSB-first order, and covers every byte sent or received, addresses included. It is appended before stop on writes and read and compared on reads. A mismatch gives status 0x9F.
- R12: An unsupported protocol code gives status 0x99 at once and issues no bus operation.
- R13: If opAck does not arrive within TIMEOUT_CYCLES of a request, opReq drops and the status becomes 0x98.
- R14: A transaction without error sets status 0x80 once its stop has been acknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWrEn | input | 1 | Host register write strobe |
| regWrAddr | input | 6 | Host write offset |
| regWrData | input | 8 | Host write data |
| regRdAddr | input | 6 | Host read offset |
| regRdData | output | 8 | Combinational read data |
| opReq | output | 1 | Bus operation request |
| opKind | output | 2 | Operation kind |
| opByte | output | 8 | Byte to send for write operations |
| opNackLast | output | 1 | Master NACKs this read byte |
| opAck | input | 1 | Engine completed the operation |
| opRxByte | input | 8 | Byte received by a read operation |
| opRxNack | input | 1 | Target NACKed a written byte |

## Verification
The case that is hardest to reach from the ports is a protocol write that lands while a transaction is still in flight. The engine responds too quickly for a host write to fall inside a transfer by chance. The bench therefore makes its engine model withhold acknowledgements. That freezes the sequencer on its first request, with the done flag already cleared. The bench then issues the second protocol write, reads the register back, and releases the engine. It then checks that only the first transaction reached the bus. Block reads whose received count exceeds 32, and PEC bytes that are deliberately corrupted, are produced by preloading the engine model's read queue.

// File: rtl/smbus_seq_pkg.sv
package smbus_seq_pkg;

  typedef enum logic [1:0] {
    OP_START = 2'd0,
    OP_STOP  = 2'd1,
    OP_WRITE = 2'd2,
    OP_READ  = 2'd3
  } opKind_t;

  typedef enum logic [3:0] {
    X_QUICK, X_BYTE, X_BDATA, X_WORD, X_BLOCK, X_PCALL, X_BPCALL, X_I2CBLK, X_BAD
  } xfer_t;

  localparam logic [4:0] RC_OK      = 5'h00;
  localparam logic [4:0] RC_DNAK    = 5'h10;
  localparam logic [4:0] RC_DERR    = 5'h11;
  localparam logic [4:0] RC_TIMEOUT = 5'h18;
  localparam logic [4:0] RC_UNSUP   = 5'h19;
  localparam logic [4:0] RC_PEC     = 5'h1F;

  typedef struct packed {
    logic       clearDone;
    logic       setStatus;
    logic [4:0] code;
    logic       crcClear;
    logic       crcUpdate;
    logic       crcFromRx;
    logic       storeData;
    logic       storeCount;
  } dpCtl_t;

  function automatic xfer_t protoDecode(input logic [6:0] p);
    case (p)
      7'h02, 7'h03: return X_QUICK;
      7'h04, 7'h05: return X_BYTE;
      7'h06, 7'h07: return X_BDATA;
      7'h08, 7'h09: return X_WORD;
      7'h0A, 7'h0B: return X_BLOCK;
      7'h0C:        return X_PCALL;
      7'h0D:        return X_BPCALL;
      7'h4A, 7'h4B: return X_I2CBLK;
      default:      return X_BAD;
    endcase
  endfunction

  function automatic logic [7:0] crc8Next(input logic [7:0] crc, input logic [7:0] b);
    logic [7:0] c;
    c = crc ^ b;
    for (int i = 0; i < 8; i++) c = c[7] ? ((c << 1) ^ 8'h07) : (c << 1);
    return c;
  endfunction

endpackage

// File: rtl/smbus_seq_dp.sv
module smbus_seq_dp
  import smbus_seq_pkg::*;
#(
  parameter int DATA_BYTES = 32,
  parameter int ADDR_W     = 6,
  localparam int IDX_W     = $clog2(DATA_BYTES),
  localparam int CNT_W     = $clog2(DATA_BYTES + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              hostWrEn,
  input  logic [ADDR_W-1:0] hostWrAddr,
  input  logic [7:0]        hostWrData,
  input  logic [ADDR_W-1:0] hostRdAddr,
  output logic [7:0]        hostRdData,
  input  logic              busy,
  input  dpCtl_t            dpCtl,
  input  logic [IDX_W-1:0]  idx,
  input  logic [7:0]        txByte,
  input  logic [7:0]        rxByte,
  output logic [6:0]        targetAddr,
  output logic [7:0]        cmdByte,
  output logic [CNT_W-1:0]  countLen,
  output logic [7:0]        dataAtIdx,
  output logic [7:0]        crcValue
);
  localparam logic [ADDR_W-1:0] A_PROTO = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] A_STAT  = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] A_ADDR  = ADDR_W'(2);
  localparam logic [ADDR_W-1:0] A_CMD   = ADDR_W'(3);
  localparam logic [ADDR_W-1:0] A_DATA  = ADDR_W'(4);
  localparam logic [ADDR_W-1:0] A_COUNT = ADDR_W'(4 + DATA_BYTES);
  localparam logic [7:0]        MAX_CNT = 8'(DATA_BYTES);

  logic [7:0] protoReg, addrReg, cmdReg, countReg, crcReg;
  logic [7:0] dataMem [DATA_BYTES];
  logic       statusDone;
  logic [4:0] statusCode;

  function automatic logic [7:0] clampCnt(input logic [7:0] v);
    return (v > MAX_CNT) ? MAX_CNT : v;
  endfunction

  logic              hostHitsData;
  logic [IDX_W-1:0]  hostIdx;
  logic [ADDR_W-1:0] hostOff, rdOff;
  assign hostOff      = hostWrAddr - A_DATA;
  assign hostIdx      = hostOff[IDX_W-1:0];
  assign hostHitsData = (hostWrAddr >= A_DATA) && (hostWrAddr < A_COUNT);
  assign rdOff        = hostRdAddr - A_DATA;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      protoReg   <= '0;
      addrReg    <= '0;
      cmdReg     <= '0;
      countReg   <= '0;
      crcReg     <= '0;
      statusDone <= 1'b0;
      statusCode <= '0;
      for (int i = 0; i < DATA_BYTES; i++) dataMem[i] <= '0;
    end else begin
      if (hostWrEn) begin
        if (hostWrAddr == A_PROTO && !busy) protoReg <= hostWrData;
        if (hostWrAddr == A_ADDR)  addrReg  <= hostWrData;
        if (hostWrAddr == A_CMD)   cmdReg   <= hostWrData;
        if (hostWrAddr == A_COUNT) countReg <= clampCnt(hostWrData);
        if (hostHitsData)          dataMem[hostIdx] <= hostWrData;
      end
      if (dpCtl.storeData)  dataMem[idx] <= rxByte;
      if (dpCtl.storeCount) countReg     <= clampCnt(rxByte);
      if (dpCtl.crcClear)       crcReg <= '0;
      else if (dpCtl.crcUpdate) crcReg <= crc8Next(crcReg, dpCtl.crcFromRx ? rxByte : txByte);
      if (dpCtl.setStatus) begin
        statusDone <= 1'b1;
        statusCode <= dpCtl.code;
      end else if (dpCtl.clearDone) begin
        statusDone <= 1'b0;
      end
    end
  end

  always_comb begin
    hostRdData = '0;
    if (hostRdAddr == A_PROTO)      hostRdData = protoReg;
    else if (hostRdAddr == A_STAT)  hostRdData = {statusDone, 2'b00, statusCode};
    else if (hostRdAddr == A_ADDR)  hostRdData = addrReg;
    else if (hostRdAddr == A_CMD)   hostRdData = cmdReg;
    else if (hostRdAddr == A_COUNT) hostRdData = countReg;
    else if (hostRdAddr > A_DATA - 1 && hostRdAddr < A_COUNT)
      hostRdData = dataMem[rdOff[IDX_W-1:0]];
  end

  assign targetAddr = addrReg[7:1];
  assign cmdByte    = cmdReg;
  assign countLen   = countReg[CNT_W-1:0];
  assign dataAtIdx  = dataMem[idx];
  assign crcValue   = crcReg;

  AST_COUNT_CLAMP: assert property (@(posedge clk) disable iff (!rstN)
    countReg <= MAX_CNT);                                                   // R6
  AST_PROTO_HELD: assert property (@(posedge clk) disable iff (!rstN)
    (busy && $past(busy)) |-> $stable(protoReg));                           // R2
  AST_DONE_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    (dpCtl.clearDone && !dpCtl.setStatus) |=> !statusDone);                 // R2

endmodule

// File: rtl/smbus_seq_ctrl.sv
module smbus_seq_ctrl
  import smbus_seq_pkg::*;
#(
  parameter int DATA_BYTES     = 32,
  parameter int TIMEOUT_CYCLES = 512,
  localparam int IDX_W         = $clog2(DATA_BYTES),
  localparam int CNT_W         = $clog2(DATA_BYTES + 1),
  localparam int TMO_W         = $clog2(TIMEOUT_CYCLES + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             protoWrite,
  input  logic [7:0]       protoData,
  input  logic [6:0]       targetAddr,
  input  logic [7:0]       cmdByte,
  input  logic [CNT_W-1:0] countLen,
  input  logic [7:0]       dataAtIdx,
  input  logic [7:0]       crcValue,
  output logic             opReq,
  output opKind_t          opKind,
  output logic [7:0]       opByte,
  output logic             opNackLast,
  input  logic             opAck,
  input  logic [7:0]       opRxByte,
  input  logic             opRxNack,
  output logic             busy,
  output logic [IDX_W-1:0] idx,
  output dpCtl_t           dpCtl
);
  localparam logic [7:0] MAX_CNT = 8'(DATA_BYTES);

  typedef enum logic [3:0] {
    S_IDLE, S_START, S_ADDR1, S_CMD, S_WCNT, S_WDATA, S_WPEC,
    S_RSTART, S_ADDR2, S_RCNT, S_RDATA, S_RPEC, S_STOP
  } state_t;

  state_t           state, stateNext;
  xfer_t            xType, newType;
  logic             isRd, usePec;
  logic [4:0]       errCode, errNext;
  logic [IDX_W-1:0] idxNext;
  logic [CNT_W-1:0] len, lenNext;
  logic [TMO_W-1:0] waitCnt;
  logic             timedOut, lastIdx, isCall;
  logic [7:0]       rxClamped;
  state_t           stWrDone, stRdDone;

  assign newType   = protoDecode(protoData[6:0]);
  assign busy      = (state != S_IDLE);
  assign lastIdx   = (CNT_W'(idx) + CNT_W'(1)) == len;
  assign isCall    = (xType == X_PCALL) || (xType == X_BPCALL);
  assign stWrDone  = isCall ? S_RSTART : (usePec ? S_WPEC : S_STOP);
  assign stRdDone  = usePec ? S_RPEC : S_STOP;
  assign rxClamped = (opRxByte > MAX_CNT) ? MAX_CNT : opRxByte;

  always_comb begin
    opReq      = 1'b1;
    opKind     = OP_WRITE;
    opByte     = '0;
    opNackLast = 1'b0;
    case (state)
      S_IDLE:           opReq = 1'b0;
      S_START,
      S_RSTART:         opKind = OP_START;
      S_STOP:           opKind = OP_STOP;
      S_ADDR1:          opByte = {targetAddr,
                                  ((xType == X_QUICK) || (xType == X_BYTE)) ? isRd : 1'b0};
      S_ADDR2:          opByte = {targetAddr, 1'b1};
      S_CMD:            opByte = cmdByte;
      S_WCNT:           opByte = 8'(countLen);
      S_WDATA:          opByte = dataAtIdx;
      S_WPEC:           opByte = crcValue;
      S_RCNT:           opKind = OP_READ;
      S_RDATA: begin
        opKind     = OP_READ;
        opNackLast = lastIdx && !usePec;
      end
      S_RPEC: begin
        opKind     = OP_READ;
        opNackLast = 1'b1;
      end
      default:          opReq = 1'b0;
    endcase
  end

  assign timedOut = opReq && !opAck && (waitCnt == TMO_W'(TIMEOUT_CYCLES - 1));

  always_comb begin
    stateNext = state;
    idxNext   = idx;
    lenNext   = len;
    errNext   = errCode;
    dpCtl     = '0;
    if (timedOut) begin
      dpCtl.setStatus = 1'b1;
      dpCtl.code      = RC_TIMEOUT;
      stateNext       = S_IDLE;
    end else if (state == S_IDLE) begin
      if (protoWrite) begin
        dpCtl.clearDone = 1'b1;
        dpCtl.crcClear  = 1'b1;
        errNext         = RC_OK;
        idxNext         = '0;
        if (newType == X_BAD) begin
          dpCtl.setStatus = 1'b1;
          dpCtl.code      = RC_UNSUP;
        end else begin
          stateNext = S_START;
        end
      end
    end else if (opAck) begin
      case (state)
        S_START:  stateNext = S_ADDR1;
        S_RSTART: stateNext = S_ADDR2;
        S_ADDR1: begin
          dpCtl.crcUpdate = 1'b1;
          if (opRxNack) begin
            errNext = RC_DNAK; stateNext = S_STOP;
          end else begin
            case (xType)
              X_QUICK: stateNext = S_STOP;
              X_BYTE:  if (isRd) begin idxNext = '0; lenNext = CNT_W'(1); stateNext = S_RDATA; end
                       else stateNext = S_CMD;
              default: stateNext = S_CMD;
            endcase
          end
        end
        S_CMD: begin
          dpCtl.crcUpdate = 1'b1;
          idxNext = '0;
          if (opRxNack) begin
            errNext = RC_DERR; stateNext = S_STOP;
          end else begin
            case (xType)
              X_BYTE:   stateNext = stWrDone;
              X_BDATA:  if (isRd) stateNext = S_RSTART;
                        else begin lenNext = CNT_W'(1); stateNext = S_WDATA; end
              X_WORD:   if (isRd) stateNext = S_RSTART;
                        else begin lenNext = CNT_W'(2); stateNext = S_WDATA; end
              X_PCALL:  begin lenNext = CNT_W'(2); stateNext = S_WDATA; end
              X_BLOCK:  stateNext = isRd ? S_RSTART : S_WCNT;
              X_BPCALL: stateNext = S_WCNT;
              X_I2CBLK: if (isRd) stateNext = S_RSTART;
                        else if (countLen == '0) stateNext = stWrDone;
                        else begin lenNext = countLen; stateNext = S_WDATA; end
              default:  stateNext = S_STOP;
            endcase
          end
        end
        S_WCNT: begin
          dpCtl.crcUpdate = 1'b1;
          lenNext = countLen;
          if (opRxNack) begin errNext = RC_DERR; stateNext = S_STOP; end
          else stateNext = (countLen == '0) ? stWrDone : S_WDATA;
        end
        S_WDATA: begin
          dpCtl.crcUpdate = 1'b1;
          idxNext = idx + 1'b1;
          if (opRxNack) begin errNext = RC_DERR; stateNext = S_STOP; end
          else if (lastIdx) begin idxNext = '0; stateNext = stWrDone; end
        end
        S_WPEC: begin
          if (opRxNack) errNext = RC_DERR;
          stateNext = S_STOP;
        end
        S_ADDR2: begin
          dpCtl.crcUpdate = 1'b1;
          idxNext = '0;
          if (opRxNack) begin
            errNext = RC_DNAK; stateNext = S_STOP;
          end else begin
            case (xType)
              X_BLOCK, X_BPCALL: stateNext = S_RCNT;
              X_BDATA:           begin lenNext = CNT_W'(1); stateNext = S_RDATA; end
              X_WORD, X_PCALL:   begin lenNext = CNT_W'(2); stateNext = S_RDATA; end
              default:           if (countLen == '0) stateNext = stRdDone;
                                 else begin lenNext = countLen; stateNext = S_RDATA; end
            endcase
          end
        end
        S_RCNT: begin
          dpCtl.crcUpdate  = 1'b1;
          dpCtl.crcFromRx  = 1'b1;
          dpCtl.storeCount = 1'b1;
          lenNext = rxClamped[CNT_W-1:0];
          stateNext = (rxClamped == 8'd0) ? stRdDone : S_RDATA;
        end
        S_RDATA: begin
          dpCtl.crcUpdate = 1'b1;
          dpCtl.crcFromRx = 1'b1;
          dpCtl.storeData = 1'b1;
          idxNext = idx + 1'b1;
          if (lastIdx) stateNext = stRdDone;
        end
        S_RPEC: begin
          if (opRxByte != crcValue) errNext = RC_PEC;
          stateNext = S_STOP;
        end
        S_STOP: begin
          dpCtl.setStatus = 1'b1;
          dpCtl.code      = errCode;
          stateNext       = S_IDLE;
        end
        default: stateNext = S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= S_IDLE;
      xType   <= X_QUICK;
      isRd    <= 1'b0;
      usePec  <= 1'b0;
      errCode <= RC_OK;
      idx     <= '0;
      len     <= '0;
      waitCnt <= '0;
    end else begin
      state   <= stateNext;
      errCode <= errNext;
      idx     <= idxNext;
      len     <= lenNext;
      if (!opReq || opAck || timedOut) waitCnt <= '0;
      else                             waitCnt <= waitCnt + 1'b1;
      if (state == S_IDLE && protoWrite) begin
        xType  <= newType;
        isRd   <= protoData[0];
        usePec <= protoData[7] && (newType != X_QUICK) && (newType != X_I2CBLK);
      end
    end
  end

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (opReq && !opAck && !timedOut) |=> (opReq && $stable(opKind) && $stable(opByte))); // R3
  AST_NACK_ONLY_READ: assert property (@(posedge clk) disable iff (!rstN)
    (opReq && opNackLast) |-> (opKind == OP_READ));                                    // R9
  AST_UNSUP_SILENT: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && protoWrite && newType == X_BAD) |=> !opReq);                             // R12
  AST_TIMEOUT_DROP: assert property (@(posedge clk) disable iff (!rstN)
    timedOut |=> !opReq);                                                              // R13

endmodule

// File: rtl/smbus_seq.sv
module smbus_seq
  import smbus_seq_pkg::*;
#(
  parameter int DATA_BYTES     = 32,
  parameter int ADDR_W         = 6,
  parameter int TIMEOUT_CYCLES = 512
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [ADDR_W-1:0] regWrAddr,
  input  logic [7:0]        regWrData,
  input  logic [ADDR_W-1:0] regRdAddr,
  output logic [7:0]        regRdData,
  output logic              opReq,
  output logic [1:0]        opKind,
  output logic [7:0]        opByte,
  output logic              opNackLast,
  input  logic              opAck,
  input  logic [7:0]        opRxByte,
  input  logic              opRxNack
);
  localparam int IDX_W = $clog2(DATA_BYTES);
  localparam int CNT_W = $clog2(DATA_BYTES + 1);

  dpCtl_t           dpCtl;
  opKind_t          kindInt;
  logic             busy, protoWrite;
  logic [IDX_W-1:0] idx;
  logic [6:0]       targetAddr;
  logic [7:0]       cmdByte, dataAtIdx, crcValue;
  logic [CNT_W-1:0] countLen;

  assign protoWrite = regWrEn && (regWrAddr == '0);
  assign opKind     = kindInt;

  smbus_seq_dp #(.DATA_BYTES(DATA_BYTES), .ADDR_W(ADDR_W)) u_dp (
    .clk(clk), .rstN(rstN),
    .hostWrEn(regWrEn), .hostWrAddr(regWrAddr), .hostWrData(regWrData),
    .hostRdAddr(regRdAddr), .hostRdData(regRdData),
    .busy(busy), .dpCtl(dpCtl), .idx(idx),
    .txByte(opByte), .rxByte(opRxByte),
    .targetAddr(targetAddr), .cmdByte(cmdByte), .countLen(countLen),
    .dataAtIdx(dataAtIdx), .crcValue(crcValue)
  );

  smbus_seq_ctrl #(.DATA_BYTES(DATA_BYTES), .TIMEOUT_CYCLES(TIMEOUT_CYCLES)) u_ctrl (
    .clk(clk), .rstN(rstN),
    .protoWrite(protoWrite), .protoData(regWrData),
    .targetAddr(targetAddr), .cmdByte(cmdByte), .countLen(countLen),
    .dataAtIdx(dataAtIdx), .crcValue(crcValue),
    .opReq(opReq), .opKind(kindInt), .opByte(opByte), .opNackLast(opNackLast),
    .opAck(opAck), .opRxByte(opRxByte), .opRxNack(opRxNack),
    .busy(busy), .idx(idx), .dpCtl(dpCtl)
  );

endmodule

// File: tb/smbus_seq_tb.sv
`timescale 1ns/1ps
module smbus_seq_tb;
  localparam logic [1:0] K_ST = 2'd0, K_SP = 2'd1, K_WR = 2'd2, K_RD = 2'd3;

  logic       clk = 1'b0, rstN = 1'b0;
  logic       regWrEn = 1'b0;
  logic [5:0] regWrAddr = '0, regRdAddr = '0;
  logic [7:0] regWrData = '0, regRdData;
  logic       opReq, opNackLast, opAck = 1'b0, opRxNack = 1'b0;
  logic [1:0] opKind;
  logic [7:0] opByte, opRxByte = '0;

  always #2 clk = ~clk;

  smbus_seq u_dut (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regWrAddr(regWrAddr),
    .regWrData(regWrData), .regRdAddr(regRdAddr), .regRdData(regRdData),
    .opReq(opReq), .opKind(opKind), .opByte(opByte), .opNackLast(opNackLast),
    .opAck(opAck), .opRxByte(opRxByte), .opRxNack(opRxNack)
  );

  int checks = 0, fails = 0;
  bit finished = 0;

  // engine model
  bit         hang = 0;
  int         nackAt = -1;
  logic [1:0] logK [64];
  logic [7:0] logB [64];
  logic       logN [64];
  int         logCnt = 0;
  logic [7:0] rdQ [48];
  int         rdPtr = 0;
  logic [1:0] expK [64];
  logic [7:0] expB [64];
  logic       expN [64];
  int         expCnt = 0;

  always @(negedge clk) begin
    if (opAck) begin
      opAck    <= 1'b0;
      opRxNack <= 1'b0;
    end else if (opReq && !hang) begin
      if (logCnt < 64) begin
        logK[logCnt] = opKind; logB[logCnt] = opByte; logN[logCnt] = opNackLast;
      end
      opRxNack <= (logCnt == nackAt);
      if (opKind == K_RD) begin opRxByte <= rdQ[rdPtr]; rdPtr = rdPtr + 1; end
      logCnt = logCnt + 1;
      opAck <= 1'b1;
    end
  end

  function automatic logic [7:0] crcOf(input logic [7:0] c, input logic [7:0] b);
    logic [7:0] r = c ^ b;
    for (int i = 0; i < 8; i++) r = r[7] ? ((r << 1) ^ 8'h07) : (r << 1);
    return r;
  endfunction

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [7:0] d);
    @(negedge clk); regWrEn = 1'b1; regWrAddr = a; regWrData = d;
    @(negedge clk); regWrEn = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [7:0] d);
    regRdAddr = a; #0.5; d = regRdData;
  endtask

  task automatic clearLog();
    logCnt = 0; expCnt = 0; rdPtr = 0; nackAt = -1;
  endtask

  task automatic ex(input logic [1:0] k, input logic [7:0] b, input logic n);
    expK[expCnt] = k; expB[expCnt] = b; expN[expCnt] = n; expCnt++;
  endtask

  task automatic waitDone(output logic [7:0] st);
    st = 8'h00;
    for (int i = 0; i < 5000; i++) begin
      rd(6'h01, st);
      if (st[7]) break;
      @(negedge clk);
    end
  endtask

  task automatic runXfer(input logic [7:0] proto, output logic [7:0] st);
    wr(6'h00, proto);
    waitDone(st);
  endtask

  task automatic cmpSeq(input string tag);
    int bad = -1;
    if (logCnt != expCnt) bad = 999;
    else for (int i = 0; i < expCnt; i++)
      if (bad < 0 && (logK[i] != expK[i] || logN[i] != expN[i] ||
                      (expK[i] == K_WR && logB[i] != expB[i]))) bad = i;
    checks++;
    if (bad >= 0) begin
      fails++;
      if (bad == 999) $display("FAIL %s op count actual=%0d expected=%0d", tag, logCnt, expCnt);
      else $display("FAIL %s op %0d actual=%0h/%0h/%0b expected=%0h/%0h/%0b", tag, bad,
                    logK[bad], logB[bad], logN[bad], expK[bad], expB[bad], expN[bad]);
    end
  endtask

  task automatic tReset();
    logic [7:0] st;
    rd(6'h01, st);
    check("R1 status after reset", st, 8'h00);
    check("R1 opReq after reset", opReq, 0);
  endtask

  task automatic tQuick();
    logic [7:0] st;
    clearLog(); wr(6'h02, 8'hA0);
    runXfer(8'h03, st);
    ex(K_ST,0,0); ex(K_WR,8'hA1,0); ex(K_SP,0,0);
    cmpSeq("R4 quick read sequence");
    check("R14 quick status", st, 8'h80);
  endtask

  task automatic tByteRead();
    logic [7:0] st, d;
    clearLog(); rdQ[0] = 8'h5C;
    runXfer(8'h05, st);
    ex(K_ST,0,0); ex(K_WR,8'hA1,0); ex(K_RD,0,1); ex(K_SP,0,0);
    cmpSeq("R5 R9 byte read sequence");
    rd(6'h04, d); check("R5 byte read stored", d, 8'h5C);
  endtask

  task automatic tWord();
    logic [7:0] st, d;
    clearLog(); wr(6'h03, 8'h22); wr(6'h04, 8'h11); wr(6'h05, 8'h99);
    runXfer(8'h08, st);
    ex(K_ST,0,0); ex(K_WR,8'hA0,0); ex(K_WR,8'h22,0); ex(K_WR,8'h11,0); ex(K_WR,8'h99,0); ex(K_SP,0,0);
    cmpSeq("R5 word write sequence");
    clearLog(); rdQ[0] = 8'h34; rdQ[1] = 8'h12;
    runXfer(8'h09, st);
    ex(K_ST,0,0); ex(K_WR,8'hA0,0); ex(K_WR,8'h22,0); ex(K_ST,0,0); ex(K_WR,8'hA1,0);
    ex(K_RD,0,0); ex(K_RD,0,1); ex(K_SP,0,0);
    cmpSeq("R5 R9 word read sequence");
    rd(6'h04, d); check("R5 word low byte", d, 8'h34);
    rd(6'h05, d); check("R5 word high byte", d, 8'h12);
    check("R14 word read status", st, 8'h80);
  endtask

  task automatic tBlock();
    logic [7:0] st, d;
    wr(6'h24, 8'd40); rd(6'h24, d); check("R6 host count clamp", d, 32);
    clearLog(); wr(6'h24, 8'd3); wr(6'h04, 8'hB0); wr(6'h05, 8'hB1); wr(6'h06, 8'hB2);
    runXfer(8'h0A, st);
    ex(K_ST,0,0); ex(K_WR,8'hA0,0); ex(K_WR,8'h22,0); ex(K_WR,8'd3,0);
    ex(K_WR,8'hB0,0); ex(K_WR,8'hB1,0); ex(K_WR,8'hB2,0); ex(K_SP,0,0);
    cmpSeq("R6 block write sequence");
    clearLog(); rdQ[0] = 8'd40;
    for (int i = 0; i < 32; i++) rdQ[i+1] = 8'(8'h40 + i);
    runXfer(8'h0B, st);
    ex(K_ST,0,0); ex(K_WR,8'hA0,0); ex(K_WR,8'h22,0); ex(K_ST,0,0); ex(K_WR,8'hA1,0); ex(K_RD,0,0);
    for (int i = 0; i < 32; i++) ex(K_RD, 0, i == 31);
    ex(K_SP,0,0);
    cmpSeq("R6 R9 block read clamped sequence");
    rd(6'h24, d); check("R6 received count clamped", d, 32);
    rd(6'h23, d); check("R6 last block byte", d, 8'h5F);
  endtask

  task automatic tCalls();
    logic [7:0] st, d;
    clearLog(); wr(6'h04, 8'h0A); wr(6'h05, 8'h0B); rdQ[0] = 8'hC1; rdQ[1] = 8'hC2;
    runXfer(8'h0C, st);
    ex(K_ST,0,0); ex(K_WR,8'hA0,0); ex(K_WR,8'h22,0); ex(K_WR,8'h0A,0); ex(K_WR,8'h0B,0);
    ex(K_ST,0,0); ex(K_WR,8'hA1,0); ex(K_RD,0,0); ex(K_RD,0,1); ex(K_SP,0,0);
    cmpSeq("R7 process call sequence");
    rd(6'h05, d); check("R7 process call reply high", d, 8'hC2);
    clearLog(); wr(6'h24, 8'd2); rdQ[0] = 8'd1; rdQ[1] = 8'hE7;
    runXfer(8'h0D, st);
    ex(K_ST,0,0); ex(K_WR,8'hA0,0); ex(K_WR,8'h22,0); ex(K_WR,8'd2,0); ex(K_WR,8'hC1,0); ex(K_WR,8'hC2,0);
    ex(K_ST,0,0); ex(K_WR,8'hA1,0); ex(K_RD,0,0); ex(K_RD,0,1); ex(K_SP,0,0);
    cmpSeq("R7 block process call sequence");
    rd(6'h24, d); check("R7 block call count", d, 1);
    rd(6'h04, d); check("R7 block call data", d, 8'hE7);
  endtask

  task automatic tI2cBlock();
    logic [7:0] st, d;
    clearLog(); wr(6'h24, 8'd4);
    for (int i = 0; i < 4; i++) rdQ[i] = 8'(8'h70 + i);
    runXfer(8'hCB, st);
    ex(K_ST,0,0); ex(K_WR,8'hA0,0); ex(K_WR,8'h22,0); ex(K_ST,0,0); ex(K_WR,8'hA1,0);
    ex(K_RD,0,0); ex(K_RD,0,0); ex(K_RD,0,0); ex(K_RD,0,1); ex(K_SP,0,0);
    cmpSeq("R8 R11 raw block read no count no PEC");
    rd(6'h07, d); check("R8 raw block last byte", d, 8'h73);
  endtask

  task automatic tNacks();
    logic [7:0] st;
    clearLog(); nackAt = 1;
    runXfer(8'h08, st);
    ex(K_ST,0,0); ex(K_WR,8'hA0,0); ex(K_SP,0,0);
    cmpSeq("R10 address NACK sequence");
    check("R10 address NACK status", st, 8'h90);
    clearLog(); nackAt = 2;
    runXfer(8'h08, st);
    ex(K_ST,0,0); ex(K_WR,8'hA0,0); ex(K_WR,8'h22,0); ex(K_SP,0,0);
    cmpSeq("R10 data NACK sequence");
    check("R10 data NACK status", st, 8'h91);
  endtask

  task automatic tPec();
    logic [7:0] st, c;
    clearLog(); wr(6'h04, 8'h11); wr(6'h05, 8'h99);
    c = crcOf(crcOf(crcOf(crcOf(8'h00, 8'hA0), 8'h22), 8'h11), 8'h99);
    runXfer(8'h88, st);
    ex(K_ST,0,0); ex(K_WR,8'hA0,0); ex(K_WR,8'h22,0); ex(K_WR,8'h11,0); ex(K_WR,8'h99,0);
    ex(K_WR,c,0); ex(K_SP,0,0);
    cmpSeq("R11 PEC appended on word write");
    c = crcOf(crcOf(crcOf(crcOf(crcOf(8'h00, 8'hA0), 8'h22), 8'hA1), 8'h34), 8'h12);
    clearLog(); rdQ[0] = 8'h34; rdQ[1] = 8'h12; rdQ[2] = c;
    runXfer(8'h89, st);
    ex(K_ST,0,0); ex(K_WR,8'hA0,0); ex(K_WR,8'h22,0); ex(K_ST,0,0); ex(K_WR,8'hA1,0);
    ex(K_RD,0,0); ex(K_RD,0,0); ex(K_RD,0,1); ex(K_SP,0,0);
    cmpSeq("R11 R9 PEC word read sequence");
    check("R11 good PEC status", st, 8'h80);
    clearLog(); rdQ[0] = 8'h34; rdQ[1] = 8'h12; rdQ[2] = c ^ 8'h01;
    runXfer(8'h89, st);
    check("R11 bad PEC status", st, 8'h9F);
  endtask

  task automatic tUnsup();
    logic [7:0] st;
    clearLog();
    runXfer(8'h10, st);
    check("R12 unsupported status", st, 8'h99);
    repeat (4) @(negedge clk);
    check("R12 no bus operations", logCnt, 0);
  endtask

  task automatic tBusyAndTimeout();
    logic [7:0] st, d;
    logic [1:0] k0;
    clearLog(); hang = 1;
    wr(6'h00, 8'h02);
    rd(6'h01, st); check("R2 done cleared on start", st[7], 0);
    k0 = opKind;
    repeat (5) @(negedge clk);
    check("R3 request held while waiting", opReq, 1);
    check("R3 kind stable while waiting", opKind, k0);
    wr(6'h00, 8'h04);
    rd(6'h00, d); check("R2 protocol write ignored while busy", d, 8'h02);
    hang = 0;
    waitDone(st);
    ex(K_ST,0,0); ex(K_WR,8'hA0,0); ex(K_SP,0,0);
    repeat (10) @(negedge clk);
    cmpSeq("R2 only first transaction ran");
    clearLog(); hang = 1;
    runXfer(8'h02, st);
    check("R13 timeout status", st, 8'h98);
    @(negedge clk);
    check("R13 request dropped", opReq, 0);
    hang = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      fails++; checks++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    tReset();
    rstN = 1'b1;
    @(negedge clk);
    tReset();
    tQuick();
    tByteRead();
    tWord();
    tBlock();
    tCalls();
    tI2cBlock();
    tNacks();
    tPec();
    tUnsup();
    tBusyAndTimeout();
    finished = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule